// File: doc/BRIEF.md
# Multiplexed Address/Data Port Controller

This block owns two byte-wide pin ports, A and B. Each port can serve as general-purpose I/O or as part of an external bus that shares address and data on the same pins over time. A bus phase input divides every external cycle into two halves. While the phase is low, the pins present the address. While it is high, they carry data. A three-bit mode code sets the role of each pin:

- general-purpose I/O;
- a driven address line;
- a data line whose direction follows read/write;
- an address input sampled from an external tester.

Wide modes move 16 bits per data phase, one byte on each port. Narrow modes move all data through port A. A 16-bit access in a narrow mode therefore takes two data phases: the high byte goes first and the low byte second. The block samples read data on the falling phase edge. It raises a one-cycle done pulse when the last byte of a read has arrived. In the special peripheral mode, the block also records the address that the tester drives during the address phase.

Mode codes are: 000 single-chip, 001 expanded narrow, 010 expanded wide, 011 emulation narrow, 100 special peripheral. The codes 101, 110 and 111 behave as single-chip.

Top module: `mux_ad_port`

## Requirements
- R1: In modes 001, 010 and 011, while bus_phase is 0, pad_a_out equals bus_addr[15:8], pad_b_out equals bus_addr[7:0], and both output enables are all ones.
- R2: In mode 010 or 100 with narrow_acc=0, while bus_phase is 1, port A carries bus_wdata[15:8] and port B carries bus_wdata[7:0].
- R3: In mode 001, and in mode 011 unless vis_en and int_acc are both 1, a 16-bit access (narrow_acc=0) uses two data phases on port A: bus_wdata[15:8] in the first and bus_wdata[7:0] in the second. During both data phases, port B keeps driving bus_addr[7:0] with its enable all ones. This holds in every mode except 100.
- R4: A byte access (narrow_acc=1) in a bus mode that is not a visible internal access uses one data phase on port A. That phase carries bus_wdata[15:8] when bus_addr[0]=0 and bus_wdata[7:0] when bus_addr[0]=1.
- R5: During a data phase, the enables of the data pins are all ones when bus_rw=0 (write) and all zeros when bus_rw=1 (read).
- R6: In mode 100, both ports have all-zero enables while bus_phase is 0. On the first clock edge after bus_phase rises, tester_addr takes {pad_a_in, pad_b_in} as sampled on the last edge of the low phase. In a byte-access data phase, port B has an all-zero enable. tester_addr changes in no other mode.
- R7: In mode 011 with vis_en=1 and int_acc=1, the data phase uses both ports as in R2, whatever narrow_acc is.
- R8: In mode 000, pad_a_out/pad_a_oe equal gpio_a_dat/gpio_a_dir and pad_b_out/pad_b_oe equal gpio_b_dat/gpio_b_dir in both phases. No read data is captured.
- R9: Mode codes 101, 110 and 111 behave exactly as mode 000.
- R10: On the first clock edge where bus_phase is 0 after being 1, a read in a bus mode stores the pins as sampled on the last high-phase edge:
  - 16-bit transfer on both ports: {A,B} into rd_data.
  - First beat of a two-beat access, or a byte access with bus_addr[0]=0: A into rd_data[15:8].
  - Second beat, or a byte access with bus_addr[0]=1: A into rd_data[7:0].
  - rd_done is high for exactly the one cycle after the final data phase of a read.
  - rd_data is unchanged at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phase | input | 1 | External bus clock phase: 0 address, 1 data |
| mode_code | input | 3 | Operating mode |
| vis_en | input | 1 | Show internal accesses on the bus in emulation narrow mode |
| int_acc | input | 1 | Current access is internal |
| narrow_acc | input | 1 | Current access is a single byte |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 16 | Write data |
| gpio_a_dat | input | 8 | Port A general-purpose output value |
| gpio_a_dir | input | 8 | Port A general-purpose direction (1 = output) |
| gpio_b_dat | input | 8 | Port B general-purpose output value |
| gpio_b_dir | input | 8 | Port B general-purpose direction (1 = output) |
| pad_a_in | input | 8 | Port A pin input |
| pad_b_in | input | 8 | Port B pin input |
| pad_a_out | output | 8 | Port A pin output value |
| pad_a_oe | output | 8 | Port A per-pin output enable |
| pad_b_out | output | 8 | Port B pin output value |
| pad_b_oe | output | 8 | Port B per-pin output enable |
| rd_data | output | 16 | Captured read data |
| rd_done | output | 1 | One-cycle pulse when a read completes |
| tester_addr | output | 16 | Address captured from the tester in mode 100 |

## Verification
The beat register is the only state behind the pad multiplexing. If it is wrong, port A shows the wrong byte in the second data phase of a narrow 16-bit access, and the error appears at the pins within that same phase. If the phase-edge detector or the capture lane is wrong, the wrong byte lane of rd_data changes, or rd_done is missing or misplaced. Either fault is visible one clock after the falling phase edge. A fault in the tester address capture shows on tester_addr one clock after the rising edge in mode 100.

// File: rtl/mad_pkg.sv
package mad_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_SINGLE  = 3'b000,
    MD_XNARROW = 3'b001,
    MD_XWIDE   = 3'b010,
    MD_EMUNAR  = 3'b011,
    MD_PERIPH  = 3'b100
  } mode_e;

  typedef struct packed {
    logic gpio;
    logic addr_in;
    logic wide_ok;
    logic narrow_bus;
    logic emul;
  } mode_dec_t;
endpackage

// File: rtl/mad_mode_dec.sv
module mad_mode_dec
  import mad_pkg::*;
(
  input  logic [MODE_W-1:0] mode_code,
  input  logic              vis_en,
  input  logic              int_acc,
  input  logic              narrow_acc,
  output logic              is_gpio,
  output logic              addr_in,
  output logic              wide16,
  output logic              two_beat
);
  mode_dec_t dec;
  logic      emu_vis;

  always_comb begin
    dec = '0;
    case (mode_code)
      MD_XNARROW: dec.narrow_bus = 1'b1;
      MD_XWIDE:   dec.wide_ok    = 1'b1;
      MD_EMUNAR:  begin dec.narrow_bus = 1'b1; dec.emul = 1'b1; end
      MD_PERIPH:  begin dec.wide_ok = 1'b1; dec.addr_in = 1'b1; end
      default:    dec.gpio = 1'b1;
    endcase
  end

  always_comb begin
    emu_vis  = dec.emul & vis_en & int_acc;
    is_gpio  = dec.gpio;
    addr_in  = dec.addr_in;
    wide16   = ~dec.gpio & ((dec.wide_ok & ~narrow_acc) | emu_vis);
    two_beat = dec.narrow_bus & ~emu_vis & ~narrow_acc;
  end
endmodule

// File: rtl/mad_lane_mux.sv
module mad_lane_mux #(
  parameter int W = 8
) (
  input  logic           is_gpio,
  input  logic           addr_in,
  input  logic           wide16,
  input  logic           two_beat,
  input  logic           phase,
  input  logic           beat,
  input  logic           rw,
  input  logic [2*W-1:0] addr,
  input  logic [2*W-1:0] wdata,
  input  logic [W-1:0]   gpo_a,
  input  logic [W-1:0]   dir_a,
  input  logic [W-1:0]   gpo_b,
  input  logic [W-1:0]   dir_b,
  output logic [W-1:0]   a_out,
  output logic [W-1:0]   a_oe,
  output logic [W-1:0]   b_out,
  output logic [W-1:0]   b_oe
);
  logic         byte_lo;
  logic [W-1:0] lane;
  logic [W-1:0] drive;

  always_comb begin
    byte_lo = two_beat ? beat : addr[0];
    lane    = byte_lo ? wdata[W-1:0] : wdata[2*W-1:W];
    drive   = {W{~rw}};
  end

  always_comb begin
    a_out = '0;
    a_oe  = '0;
    b_out = '0;
    b_oe  = '0;
    if (is_gpio) begin
      a_out = gpo_a;
      a_oe  = dir_a;
      b_out = gpo_b;
      b_oe  = dir_b;
    end else if (!phase) begin
      if (!addr_in) begin
        a_out = addr[2*W-1:W];
        b_out = addr[W-1:0];
        a_oe  = '1;
        b_oe  = '1;
      end
    end else if (wide16) begin
      a_out = wdata[2*W-1:W];
      b_out = wdata[W-1:0];
      a_oe  = drive;
      b_oe  = drive;
    end else begin
      a_out = lane;
      a_oe  = drive;
      if (!addr_in) begin
        b_out = addr[W-1:0];
        b_oe  = '1;
      end
    end
  end
endmodule

// File: rtl/mad_capture.sv
module mad_capture #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           phase,
  input  logic           is_gpio,
  input  logic           addr_in,
  input  logic           wide16,
  input  logic           two_beat,
  input  logic           rw,
  input  logic           addr0,
  input  logic [W-1:0]   pin_a,
  input  logic [W-1:0]   pin_b,
  output logic           beat,
  output logic [2*W-1:0] rd_data,
  output logic           rd_done,
  output logic [2*W-1:0] ext_addr
);
  logic           phase_q;
  logic [W-1:0]   pa_q, pb_q;
  logic           beat_q, beat_nxt;
  logic [2*W-1:0] rd_q, rd_nxt;
  logic           done_q, done_nxt;
  logic [2*W-1:0] ext_q, ext_nxt;
  logic           fall, rise, cap_en, beat_en, ext_en;

  always_comb begin
    fall    = phase_q & ~phase;
    rise    = ~phase_q & phase;
    cap_en  = fall & ~is_gpio & rw;
    beat_en = ~two_beat | fall;
    ext_en  = rise & addr_in;

    beat_nxt = two_beat ? ~beat_q : 1'b0;

    rd_nxt = rd_q;
    if (wide16) begin
      rd_nxt = {pa_q, pb_q};
    end else if (two_beat ? beat_q : addr0) begin
      rd_nxt[W-1:0] = pa_q;
    end else begin
      rd_nxt[2*W-1:W] = pa_q;
    end

    done_nxt = cap_en & (~two_beat | beat_q);
    ext_nxt  = {pa_q, pb_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pa_q    <= '0;
      pb_q    <= '0;
      beat_q  <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      ext_q   <= '0;
    end else begin
      phase_q <= phase;
      pa_q    <= pin_a;
      pb_q    <= pin_b;
      done_q  <= done_nxt;
      if (beat_en) beat_q <= beat_nxt;
      if (cap_en)  rd_q   <= rd_nxt;
      if (ext_en)  ext_q  <= ext_nxt;
    end
  end

  assign beat     = beat_q;
  assign rd_data  = rd_q;
  assign rd_done  = done_q;
  assign ext_addr = ext_q;

  AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !two_beat |=> (beat_q == 1'b0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_q && !phase) |=> $stable(rd_q)); // R10
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_in |=> $stable(ext_q)); // R6
endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port
  import mad_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int AW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_phase,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              vis_en,
  input  logic              int_acc,
  input  logic              narrow_acc,
  input  logic              bus_rw,
  input  logic [AW-1:0]     bus_addr,
  input  logic [AW-1:0]     bus_wdata,
  input  logic [BYTE_W-1:0] gpio_a_dat,
  input  logic [BYTE_W-1:0] gpio_a_dir,
  input  logic [BYTE_W-1:0] gpio_b_dat,
  input  logic [BYTE_W-1:0] gpio_b_dir,
  input  logic [BYTE_W-1:0] pad_a_in,
  input  logic [BYTE_W-1:0] pad_b_in,
  output logic [BYTE_W-1:0] pad_a_out,
  output logic [BYTE_W-1:0] pad_a_oe,
  output logic [BYTE_W-1:0] pad_b_out,
  output logic [BYTE_W-1:0] pad_b_oe,
  output logic [AW-1:0]     rd_data,
  output logic              rd_done,
  output logic [AW-1:0]     tester_addr
);
  logic rst_meta, rst_sync;
  logic is_gpio, addr_in, wide16, two_beat, beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  mad_mode_dec u_dec (
    .mode_code (mode_code),
    .vis_en    (vis_en),
    .int_acc   (int_acc),
    .narrow_acc(narrow_acc),
    .is_gpio   (is_gpio),
    .addr_in   (addr_in),
    .wide16    (wide16),
    .two_beat  (two_beat)
  );

  mad_lane_mux #(.W(BYTE_W)) u_mux (
    .is_gpio (is_gpio),
    .addr_in (addr_in),
    .wide16  (wide16),
    .two_beat(two_beat),
    .phase   (bus_phase),
    .beat    (beat),
    .rw      (bus_rw),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .gpo_a   (gpio_a_dat),
    .dir_a   (gpio_a_dir),
    .gpo_b   (gpio_b_dat),
    .dir_b   (gpio_b_dir),
    .a_out   (pad_a_out),
    .a_oe    (pad_a_oe),
    .b_out   (pad_b_out),
    .b_oe    (pad_b_oe)
  );

  mad_capture #(.W(BYTE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync),
    .phase   (bus_phase),
    .is_gpio (is_gpio),
    .addr_in (addr_in),
    .wide16  (wide16),
    .two_beat(two_beat),
    .rw      (bus_rw),
    .addr0   (bus_addr[0]),
    .pin_a   (pad_a_in),
    .pin_b   (pad_b_in),
    .beat    (beat),
    .rd_data (rd_data),
    .rd_done (rd_done),
    .ext_addr(tester_addr)
  );

  AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_gpio && !addr_in && !bus_phase) |->
      (pad_a_out == bus_addr[AW-1:BYTE_W]) && (pad_b_out == bus_addr[BYTE_W-1:0])
      && (&pad_a_oe) && (&pad_b_oe)); // R1
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_gpio && bus_phase && bus_rw) |-> (pad_a_oe == '0)); // R5
  AST_TESTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_in && !bus_phase) |-> ((pad_a_oe == '0) && (pad_b_oe == '0))); // R6
  AST_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(bus_rw)); // R10
endmodule

// File: tb/mux_ad_port_tb.sv
`timescale 1ns/1ps
module mux_ad_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_phase, vis_en, int_acc, narrow_acc, bus_rw;
  logic [2:0]  mode_code;
  logic [15:0] bus_addr, bus_wdata;
  logic [7:0]  gpio_a_dat, gpio_a_dir, gpio_b_dat, gpio_b_dir, pad_a_in, pad_b_in;
  logic [7:0]  pad_a_out, pad_a_oe, pad_b_out, pad_b_oe;
  logic [15:0] rd_data, tester_addr;
  logic        rd_done;

  int total = 0;
  int bad = 0;
  int it = 0;
  bit finished = 0;
  logic [15:0] rd_exp = 16'h0;
  logic [15:0] ext_exp = 16'h0;

  always #2.5 clk = ~clk;

  mux_ad_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .mode_code(mode_code),
    .vis_en(vis_en), .int_acc(int_acc), .narrow_acc(narrow_acc), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .gpio_a_dat(gpio_a_dat), .gpio_a_dir(gpio_a_dir),
    .gpio_b_dat(gpio_b_dat), .gpio_b_dir(gpio_b_dir),
    .pad_a_in(pad_a_in), .pad_b_in(pad_b_in),
    .pad_a_out(pad_a_out), .pad_a_oe(pad_a_oe),
    .pad_b_out(pad_b_out), .pad_b_oe(pad_b_oe),
    .rd_data(rd_data), .rd_done(rd_done), .tester_addr(tester_addr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s it=%0d mode=%0d actual=%h expected=%h", tag, it, mode_code, act, exp);
    end
  endtask

  task automatic check_pads(input string tag, input logic [7:0] ea, input logic [7:0] eoa,
                            input logic [7:0] eb, input logic [7:0] eob);
    chk({tag, " a_oe"}, {8'h0, pad_a_oe}, {8'h0, eoa});
    chk({tag, " b_oe"}, {8'h0, pad_b_oe}, {8'h0, eob});
    chk({tag, " a_out"}, {8'h0, pad_a_out & eoa}, {8'h0, ea & eoa});
    chk({tag, " b_out"}, {8'h0, pad_b_out & eob}, {8'h0, eb & eob});
  endtask

  task automatic access(input int m, input bit r, input bit n, input bit v);
    bit gp, per, emv, w16, tb2, lo;
    int nb;
    string gtag, dtag;
    logic [15:0] ta, dat;
    logic [7:0] ea, eoa, eb, eob;
    gp   = (m == 0) || (m > 4);
    per  = (m == 4);
    emv  = (m == 3) && v;
    w16  = !gp && (((m == 2 || m == 4) && !n) || emv);
    tb2  = (m == 1 || m == 3) && !emv && !n;
    nb   = tb2 ? 2 : 1;
    gtag = (m == 0) ? "R8" : "R9";
    ta   = 16'h9E00 ^ 16'(it * 16'h0B07);
    @(negedge clk);
    mode_code  = 3'(m);
    bus_rw     = r;
    narrow_acc = n;
    vis_en     = v;
    int_acc    = v;
    bus_addr   = 16'h4A20 ^ 16'(it * 16'h0313);
    bus_wdata  = 16'hC3A5 ^ 16'(it * 16'h1111);
    gpio_a_dat = 8'(it * 8'h17);
    gpio_a_dir = 8'(it * 8'h29) ^ 8'h5A;
    gpio_b_dat = 8'(it * 8'h3B) ^ 8'hC0;
    gpio_b_dir = 8'(it * 8'h0D);
    bus_phase  = 1'b0;
    pad_a_in   = ta[15:8];
    pad_b_in   = ta[7:0];
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (gp) check_pads({gtag, " addr"}, gpio_a_dat, gpio_a_dir, gpio_b_dat, gpio_b_dir);
    else if (per) check_pads("R6 addr", 8'h0, 8'h0, 8'h0, 8'h0);
    else check_pads("R1 addr", bus_addr[15:8], 8'hFF, bus_addr[7:0], 8'hFF);
    for (int b = 0; b < nb; b++) begin
      dat = 16'h6D00 ^ 16'(it * 16'h0451) ^ 16'(b * 16'h2A2A);
      bus_phase = 1'b1;
      pad_a_in  = dat[15:8];
      pad_b_in  = dat[7:0];
      @(posedge clk);
      if (per && b == 0) ext_exp = ta;
      @(negedge clk);
      chk("R6 tester_addr", tester_addr, ext_exp);
      eoa  = r ? 8'h00 : 8'hFF;
      dtag = emv ? "R7" : (w16 ? "R2" : (tb2 ? "R3" : "R4"));
      if (gp) begin
        check_pads({gtag, " data"}, gpio_a_dat, gpio_a_dir, gpio_b_dat, gpio_b_dir);
      end else if (w16) begin
        check_pads({dtag, " R5 data"}, bus_wdata[15:8], eoa, bus_wdata[7:0], eoa);
      end else begin
        lo = tb2 ? (b == 1) : bus_addr[0];
        ea = lo ? bus_wdata[7:0] : bus_wdata[15:8];
        if (per) begin eb = 8'h0; eob = 8'h0; end
        else begin eb = bus_addr[7:0]; eob = 8'hFF; end
        check_pads({dtag, (per ? " R6" : " R5"), " data"}, ea, eoa, eb, eob);
      end
      @(posedge clk);
      @(negedge clk);
      bus_phase = 1'b0;
      pad_a_in  = 8'h00;
      pad_b_in  = 8'hFF;
      @(posedge clk);
      @(negedge clk);
      if (!gp && r) begin
        if (w16) rd_exp = dat;
        else if (tb2 ? (b == 1) : bus_addr[0]) rd_exp[7:0] = dat[15:8];
        else rd_exp[15:8] = dat[15:8];
      end
      chk(gp ? {gtag, " R10 rd_data"} : "R10 rd_data", rd_data, rd_exp);
      chk("R10 rd_done", {15'h0, rd_done},
          {15'h0, (!gp && r && (b == nb - 1))});
    end
    @(negedge clk);
    chk("R10 rd_done clear", {15'h0, rd_done}, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_phase = 1'b0; mode_code = 3'b000; vis_en = 1'b0; int_acc = 1'b0;
    narrow_acc = 1'b0; bus_rw = 1'b0; bus_addr = '0; bus_wdata = '0;
    gpio_a_dat = '0; gpio_a_dir = '0; gpio_b_dat = '0; gpio_b_dir = '0;
    pad_a_in = '0; pad_b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rd_data", rd_data, 16'h0);
    chk("R10 reset rd_done", {15'h0, rd_done}, 16'h0);
    chk("R6 reset tester_addr", tester_addr, 16'h0);
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 2; r++)
        for (int n = 0; n < 2; n++)
          for (int v = 0; v < 2; v++) begin
            it++;
            access(m, r[0], n[0], v[0]);
          end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule